// File: doc/BRIEF.md
# Command Word Illegalization Decoder

This block runs next to a serial-bus remote terminal core and decides, for every received command word, whether the terminal should treat the message as illegal. The core presents the 16-bit command word on a bus and releases an active-low command-valid strobe. On the rising edge of that strobe the block forms an 11-bit index from the low bits of the command word and looks it up in a 2048 x 1 legality table. The index is built from the direction bit, the subaddress and the word count or mode code.

The lookup result drives an active-low message-illegal output. The core samples this output and sets the Message Error bit in its status reply when it is low. The output is registered and holds its value until the next command. The terminal address bits of the command word play no part in the lookup. A host loads the table through a plain address/data/write-enable port. The strobe is asynchronous to the block clock, so it passes through a flop synchronizer before its edge is detected.

Top module: `cmd_illegal_decoder`

## Requirements
- R1: The lookup index is cmd_word[10:0], that is {direction bit 10, subaddress bits 9:5, word count bits 4:0}. Bits 15:11 of cmd_word have no effect on the result.
- R2: A capture happens only on a rising edge of cmd_valid_n. A falling edge, or a strobe held at either level, leaves msg_illegal_n unchanged.
- R3: On a capture, msg_illegal_n becomes 0 if the table entry at the index holds 1 (illegal), and 1 if the entry holds 0 (legal).
- R4: With SYNC_STAGES=2, msg_illegal_n takes its new value at the third rising clock edge after cmd_valid_n goes high, and not before. At 250 MHz this is 12 ns, well inside the 600 ns limit.
- R5: Between captures msg_illegal_n stays unchanged, even when cmd_word changes while the strobe is high.
- R6: After reset msg_illegal_n is 1 and every table entry is 0, so every command reads as legal until the host writes the table.
- R7: When tbl_we is 1 at a clock edge, tbl_data is stored at tbl_addr. Any capture at a later edge sees the new value.
- R8: A host write to the entry of the currently latched command does not change msg_illegal_n until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cmd_word | input | 16 | Command word bus from the terminal core |
| cmd_valid_n | input | 1 | Active-low command strobe (asynchronous); its rising edge captures the word |
| tbl_we | input | 1 | Host table write enable |
| tbl_addr | input | 11 | Host table write address (command index) |
| tbl_data | input | 1 | Host table write value, 1 = illegal |
| msg_illegal_n | output | 1 | Active-low illegal-message flag, held until the next capture |

## Verification
The bench builds the block with its defaults: a 16-bit command word, an 11-bit index that gives the full 2048-entry table, and two synchronizer stages. The full index width lets the bench reach the table corners 0x000 and 0x7FF. It can also show that command words which differ only in the terminal address bits select the same entry. Two synchronizer stages fix the strobe-to-output latency at three edges. The bench samples that latency one edge early and at the exact edge.

// File: rtl/cmd_illegal_pkg.sv
package cmd_illegal_pkg;
  localparam int DEF_CMD_W       = 16;
  localparam int DEF_IDX_W       = 11;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/cid_strobe_sync.sv
module cid_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic rise_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              sync_out;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], strobe_async};
  end

  assign sync_out = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sync_out;
  end

  assign rise_pulse = sync_out & ~last_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R2
endmodule

// File: rtl/cid_legal_table.sv
module cid_legal_table #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (!rst_n) cells <= '0;
    else if (wr_en) cells[wr_addr] <= wr_bit;
  end

  assign rd_bit = cells[rd_addr];

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cells[$past(wr_addr)] == $past(wr_bit)); // R7
endmodule

// File: rtl/cmd_illegal_decoder.sv
module cmd_illegal_decoder
  import cmd_illegal_pkg::*;
#(
  parameter int CMD_W       = DEF_CMD_W,
  parameter int IDX_W       = DEF_IDX_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             cmd_valid_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic             tbl_data,
  output logic             msg_illegal_n
);
  function automatic logic [IDX_W-1:0] cmd_index(input logic [CMD_W-1:0] w);
    return w[IDX_W-1:0];
  endfunction

  logic             cap_pulse;
  logic [IDX_W-1:0] look_idx;
  logic             look_bit;

  cid_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_async (cmd_valid_n),
    .rise_pulse   (cap_pulse)
  );

  assign look_idx = cmd_index(cmd_word);

  cid_legal_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_bit  (tbl_data),
    .rd_addr (look_idx),
    .rd_bit  (look_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         msg_illegal_n <= 1'b1;
    else if (cap_pulse) msg_illegal_n <= ~look_bit;
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(msg_illegal_n)); // R5
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> msg_illegal_n == !$past(look_bit)); // R3
  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !cap_pulse) |=> $stable(msg_illegal_n)); // R8
endmodule

// File: tb/cmd_illegal_decoder_bench.sv
module cmd_illegal_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_valid_n = 1'b1;
  logic        tbl_we = 1'b0;
  logic [10:0] tbl_addr = '0;
  logic        tbl_data = 1'b0;
  logic        msg_illegal_n;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cmd_illegal_decoder u_cmd_illegal_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid_n(cmd_valid_n),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .msg_illegal_n(msg_illegal_n)
  );

  // {command word, expected msg_illegal_n}
  localparam logic [16:0] VEC [0:9] = '{
    {16'h07FF, 1'b0}, {16'h0124, 1'b1}, {16'hFFFF, 1'b0}, {16'hF8A3, 1'b1},
    {16'h04A3, 1'b0}, {16'h07FE, 1'b1}, {16'h0125, 1'b0}, {16'h0000, 1'b1},
    {16'h5125, 1'b0}, {16'h2FFE, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: msg_illegal_n=%b expected %b", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [10:0] a, input logic d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  // strobe low then high at a falling edge; returns 4 negedges after the rise
  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk); cmd_word = w; cmd_valid_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd_valid_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset output", msg_illegal_n, 1'b1);
    send_cmd(16'h07FF);
    check("R6 empty table legal 7FF", msg_illegal_n, 1'b1);
    send_cmd(16'h0000);
    check("R6 empty table legal 000", msg_illegal_n, 1'b1);

    host_write(11'h7FF, 1'b1);
    host_write(11'h4A3, 1'b1);
    host_write(11'h125, 1'b1);

    // R1 R3 R7 vector walk
    for (int i = 0; i < 10; i++) begin
      send_cmd(VEC[i][16:1]);
      check($sformatf("R3 R1 R7 vector %0d", i), msg_illegal_n, VEC[i][0]);
    end

    // R4 latency: legal -> illegal, rise on a falling edge
    send_cmd(16'h0001);
    check("R4 setup legal", msg_illegal_n, 1'b1);
    @(negedge clk); cmd_word = 16'h07FF; cmd_valid_n = 1'b0;
    repeat (4) @(negedge clk);
    cmd_valid_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 not yet after two edges", msg_illegal_n, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R4 valid at third edge", msg_illegal_n, 1'b0);

    // R2 falling edge alone does not capture
    repeat (2) @(negedge clk);
    cmd_word = 16'h0001; cmd_valid_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 falling edge no capture", msg_illegal_n, 1'b0);
    cmd_valid_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 rising edge captures", msg_illegal_n, 1'b1);

    // R5 bus changes while strobe high
    cmd_word = 16'h07FF;
    repeat (8) @(negedge clk);
    check("R5 hold with bus change", msg_illegal_n, 1'b1);

    // R8 write to latched entry 0x001
    host_write(11'h001, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 write latched entry no change", msg_illegal_n, 1'b1);
    send_cmd(16'h0001);
    check("R8 next capture sees write", msg_illegal_n, 1'b0);
    host_write(11'h001, 1'b0);
    check("R8 clear latched entry no change", msg_illegal_n, 1'b0);
    send_cmd(16'hF801);
    check("R7 R1 rewrite visible", msg_illegal_n, 1'b1);

    // R6 reset again restores legal output and cleared table
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset output again", msg_illegal_n, 1'b1);
    send_cmd(16'h07FF);
    check("R6 table cleared by reset", msg_illegal_n, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule